// File: doc/BRIEF.md
# Ordered Scalar Compare To Condition Flags

This unit takes two IEEE-754 scalars of a parameterised format and compares them in a single clocked stage. It reduces the outcome to the three condition flags that branch logic reads (zero, parity and carry). It clears the overflow, auxiliary-carry and sign flags and passes every other bit of the incoming flag word through untouched. Every NaN is a failed ordered compare, so the unit always reports invalid-operation when it sees one, whether the NaN is quiet or signalling. It also reports a denormal operand.

Two mask bits come in with the operands. When a raised exception is not masked, the unit asks for a trap and returns the flag word exactly as it arrived, so no condition flag changes. A result appears one clock after its request and is marked by a valid strobe.

Top module: `cmpf_top`

## Requirements
- R1: For ordered operands the flag word gets ZF (bit 6), PF (bit 2) and CF (bit 0) as follows: a greater than b gives 0,0,0; a less than b gives 0,0,1 (CF only); a equal to b gives 1,0,0 (ZF only). Infinities order as beyond every finite value of their sign.
- R2: When either operand is a NaN (exponent all ones, fraction nonzero), or both are, ZF, PF and CF are all set to 1.
- R3: On every compare that updates the flags, OF (bit 11), AF (bit 4) and SF (bit 7) are cleared to 0.
- R4: All flag bits other than bits 0, 2, 4, 6, 7 and 11 leave equal to the corresponding bits of `flags_in`.
- R5: Positive zero and negative zero compare equal, in either order and against themselves.
- R6: `stat_inv` is 1 for a compare in which any operand is a NaN, quiet or signalling, and 0 otherwise.
- R7: `stat_den` is 1 for a compare in which any operand is denormal (exponent zero, fraction nonzero), and 0 otherwise, NaN or not.
- R8: `trap_req` is 1 when `stat_inv` is 1 with `mask_inv` 0, or `stat_den` is 1 with `mask_den` 0. In that case `flags_out` equals `flags_in` in every bit. Masked exceptions set the status bits but still update the flags.
- R9: `out_valid` is 1 exactly one cycle after `in_valid`. When it is 0, the status bits and `trap_req` are 0 and `flags_out` keeps its last value.
- R10: While `rst` is high at a clock edge, every output is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compare request for this cycle |
| opnd_a | input | EXP_W+MAN_W+1 | First scalar operand |
| opnd_b | input | EXP_W+MAN_W+1 | Second scalar operand |
| flags_in | input | FLAG_W | Current flag word |
| mask_inv | input | 1 | 1 masks the invalid-operation exception |
| mask_den | input | 1 | 1 masks the denormal-operand exception |
| out_valid | output | 1 | Result valid strobe |
| flags_out | output | FLAG_W | Next flag word |
| stat_inv | output | 1 | Invalid-operation status for this result |
| stat_den | output | 1 | Denormal-operand status for this result |
| trap_req | output | 1 | Unmasked exception, flags held |

## Verification
A NaN in one operand and a denormal in the other raise invalid and denormal in the same compare. Only one of the two may be unmasked, and that decides on its own whether the flag word is frozen or rewritten. The bench provokes this by sweeping every operand pair of a 6-bit format while the two mask bits rotate through all four combinations on a different period. Each result is judged against the value predicted from the decoded operand values, so a mixed pair must show both status bits and must show the held word exactly when either raised exception is unmasked.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

  // Flag word bit positions read by downstream condition logic
  localparam int FLG_CF = 0;
  localparam int FLG_PF = 2;
  localparam int FLG_AF = 4;
  localparam int FLG_ZF = 6;
  localparam int FLG_SF = 7;
  localparam int FLG_OF = 11;
  localparam int FLG_MIN_W = FLG_OF + 1;

  typedef enum logic [1:0] {
    OUT_GT = 2'd0,
    OUT_LT = 2'd1,
    OUT_EQ = 2'd2,
    OUT_UN = 2'd3
  } cmp_out_e;

  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_nan;
    logic is_den;
  } opclass_t;

  // {zf, pf, cf} for an outcome
  function automatic logic [2:0] outcome_bits(input cmp_out_e o);
    case (o)
      OUT_GT:  outcome_bits = 3'b000;
      OUT_LT:  outcome_bits = 3'b001;
      OUT_EQ:  outcome_bits = 3'b100;
      default: outcome_bits = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/cmpf_classify.sv
module cmpf_classify
  import cmpf_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0]   op,
  output opclass_t               cls,
  output logic [EXP_W+MAN_W-1:0] mag
);

  localparam int TOP = EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_zero;
  logic             exp_ones;
  logic             man_zero;

  assign exp_f    = op[TOP-1:MAN_W];
  assign man_f    = op[MAN_W-1:0];
  assign exp_zero = (exp_f == '0);
  assign exp_ones = (exp_f == '1);
  assign man_zero = (man_f == '0);

  always_comb begin
    cls.sign    = op[TOP];
    cls.is_zero = exp_zero && man_zero;
    cls.is_nan  = exp_ones && !man_zero;
    cls.is_den  = exp_zero && !man_zero;
  end

  assign mag = op[TOP-1:0];

endmodule

// File: rtl/cmpf_order.sv
module cmpf_order
  import cmpf_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  opclass_t         cls_a,
  input  opclass_t         cls_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output cmp_out_e         res
);

  logic mag_gt;
  logic mag_eq;
  logic both_zero;

  assign mag_gt    = (mag_a > mag_b);
  assign mag_eq    = (mag_a == mag_b);
  assign both_zero = cls_a.is_zero && cls_b.is_zero;

  always_comb begin
    if (cls_a.is_nan || cls_b.is_nan) begin
      res = OUT_UN;
    end else if (both_zero) begin
      res = OUT_EQ;
    end else if (cls_a.sign != cls_b.sign) begin
      res = cls_a.sign ? OUT_LT : OUT_GT;
    end else if (mag_eq) begin
      res = OUT_EQ;
    end else if (mag_gt ^ cls_a.sign) begin
      res = OUT_GT;
    end else begin
      res = OUT_LT;
    end
  end

endmodule

// File: rtl/cmpf_flagmerge.sv
module cmpf_flagmerge
  import cmpf_pkg::*;
#(
  parameter int FLAG_W = 32
) (
  input  logic [FLAG_W-1:0] flags_in,
  input  cmp_out_e          outcome,
  input  logic              hold,
  output logic [FLAG_W-1:0] flags_next
);

  logic [2:0] zpc;
  assign zpc = outcome_bits(outcome);

  always_comb begin
    flags_next = flags_in;
    if (!hold) begin
      flags_next[FLG_ZF] = zpc[2];
      flags_next[FLG_PF] = zpc[1];
      flags_next[FLG_CF] = zpc[0];
      flags_next[FLG_OF] = 1'b0;
      flags_next[FLG_AF] = 1'b0;
      flags_next[FLG_SF] = 1'b0;
    end
  end

endmodule

// File: rtl/cmpf_top.sv
module cmpf_top
  import cmpf_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  parameter int FLAG_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [EXP_W+MAN_W:0]   opnd_a,
  input  logic [EXP_W+MAN_W:0]   opnd_b,
  input  logic [FLAG_W-1:0]      flags_in,
  input  logic                   mask_inv,
  input  logic                   mask_den,
  output logic                   out_valid,
  output logic [FLAG_W-1:0]      flags_out,
  output logic                   stat_inv,
  output logic                   stat_den,
  output logic                   trap_req
);

  localparam int OP_W  = EXP_W + MAN_W + 1;
  localparam int MAG_W = OP_W - 1;
  localparam int N_OPS = 2;

  logic [OP_W-1:0]  opnd [N_OPS];
  opclass_t         cls  [N_OPS];
  logic [MAG_W-1:0] mag  [N_OPS];

  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    cmpf_classify #(
      .EXP_W (EXP_W),
      .MAN_W (MAN_W)
    ) u_cls (
      .op  (opnd[gi]),
      .cls (cls[gi]),
      .mag (mag[gi])
    );
  end

  cmp_out_e outcome;

  cmpf_order #(
    .MAG_W (MAG_W)
  ) u_ord (
    .cls_a (cls[0]),
    .cls_b (cls[1]),
    .mag_a (mag[0]),
    .mag_b (mag[1]),
    .res   (outcome)
  );

  logic raise_inv;
  logic raise_den;
  logic raise_trap;

  assign raise_inv  = cls[0].is_nan || cls[1].is_nan;
  assign raise_den  = cls[0].is_den || cls[1].is_den;
  assign raise_trap = (raise_inv && !mask_inv) || (raise_den && !mask_den);

  logic [FLAG_W-1:0] flags_nx;

  cmpf_flagmerge #(
    .FLAG_W (FLAG_W)
  ) u_mrg (
    .flags_in   (flags_in),
    .outcome    (outcome),
    .hold       (raise_trap),
    .flags_next (flags_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      flags_out <= '0;
      stat_inv  <= 1'b0;
      stat_den  <= 1'b0;
      trap_req  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        flags_out <= flags_nx;
        stat_inv  <= raise_inv;
        stat_den  <= raise_den;
        trap_req  <= raise_trap;
      end else begin
        stat_inv  <= 1'b0;
        stat_den  <= 1'b0;
        trap_req  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cmpf_chk.sv
module cmpf_chk
  import cmpf_pkg::*;
#(
  parameter int FLAG_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [FLAG_W-1:0] flags_in,
  input logic              mask_inv,
  input logic              mask_den,
  input logic              out_valid,
  input logic [FLAG_W-1:0] flags_out,
  input logic              stat_inv,
  input logic              stat_den,
  input logic              trap_req
);

  localparam logic [FLAG_W-1:0] TOUCHED =
      (FLAG_W'(1) << FLG_CF) | (FLAG_W'(1) << FLG_PF) | (FLAG_W'(1) << FLG_AF) |
      (FLAG_W'(1) << FLG_ZF) | (FLAG_W'(1) << FLG_SF) | (FLAG_W'(1) << FLG_OF);

  // R9
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!trap_req && !stat_inv && !stat_den));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(flags_out));

  // R8
  trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && trap_req) |-> (flags_out == $past(flags_in)));

  // R8
  trap_cause_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> ((stat_inv && !$past(mask_inv)) || (stat_den && !$past(mask_den))));

  // R3
  clear_oas_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !trap_req) |->
      (!flags_out[FLG_OF] && !flags_out[FLG_AF] && !flags_out[FLG_SF]));

  // R2
  unord_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !trap_req && stat_inv) |->
      (flags_out[FLG_ZF] && flags_out[FLG_PF] && flags_out[FLG_CF]));

  // R1
  ordered_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !trap_req && !stat_inv) |->
      (!flags_out[FLG_PF] && !(flags_out[FLG_ZF] && flags_out[FLG_CF])));

  // R4
  pass_bits_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((flags_out & ~TOUCHED) == ($past(flags_in) & ~TOUCHED)));

endmodule

bind cmpf_top cmpf_chk #(.FLAG_W(FLAG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .flags_in  (flags_in),
  .mask_inv  (mask_inv),
  .mask_den  (mask_den),
  .out_valid (out_valid),
  .flags_out (flags_out),
  .stat_inv  (stat_inv),
  .stat_den  (stat_den),
  .trap_req  (trap_req)
);

// File: tb/sim_cmpf_top.sv
`timescale 1ns/1ps
module sim_cmpf_top;

  localparam int EXP_W  = 3;
  localparam int MAN_W  = 2;
  localparam int FLAG_W = 16;
  localparam int OP_W   = EXP_W + MAN_W + 1;
  localparam int NPAIR  = 1 << (2 * OP_W);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [OP_W-1:0]   opnd_a = '0;
  logic [OP_W-1:0]   opnd_b = '0;
  logic [FLAG_W-1:0] flags_in = '0;
  logic              mask_inv = 1'b1;
  logic              mask_den = 1'b1;
  logic              out_valid;
  logic [FLAG_W-1:0] flags_out;
  logic              stat_inv;
  logic              stat_den;
  logic              trap_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmpf_top #(.EXP_W(EXP_W), .MAN_W(MAN_W), .FLAG_W(FLAG_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .flags_in(flags_in), .mask_inv(mask_inv), .mask_den(mask_den),
    .out_valid(out_valid), .flags_out(flags_out), .stat_inv(stat_inv),
    .stat_den(stat_den), .trap_req(trap_req)
  );

  // Flag positions: CF 0, PF 2, AF 4, ZF 6, SF 7, OF 11
  localparam logic [FLAG_W-1:0] M_OAS = 16'h0890;
  localparam logic [FLAG_W-1:0] M_ALL = 16'h08D5;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_nan(input logic [OP_W-1:0] x);
    return (x[4:2] == 3'b111) && (x[1:0] != 2'b00);
  endfunction

  function automatic bit is_den(input logic [OP_W-1:0] x);
    return (x[4:2] == 3'b000) && (x[1:0] != 2'b00);
  endfunction

  // Exact value scaled by the smallest denormal step
  function automatic int value(input logic [OP_W-1:0] x);
    int e = int'(x[4:2]);
    int m = int'(x[1:0]);
    int mg = (e == 0) ? m : ((4 + m) << (e - 1));
    return x[5] ? -mg : mg;
  endfunction

  logic [FLAG_W-1:0] last_out;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10
    chk("R10 out_valid", 32'(out_valid), 0);
    chk("R10 flags_out", 32'(flags_out), 0);
    chk("R10 status", {29'd0, stat_inv, stat_den, trap_req}, 0);
    rst = 1'b0;

    for (int i = 0; i < NPAIR; i++) begin
      logic [OP_W-1:0] a, b;
      logic [FLAG_W-1:0] fi, ef;
      bit n, d, t, mi, md;
      int va, vb;
      string tg;
      a  = OP_W'(i >> OP_W);
      b  = OP_W'(i);
      mi = ((i / 3) % 2) != 0;
      md = ((i / 5) % 2) != 0;
      fi = FLAG_W'(i * 40503) ^ FLAG_W'(i >> 3) ^ 16'hA5C3;
      opnd_a = a; opnd_b = b; flags_in = fi;
      mask_inv = mi; mask_den = md; in_valid = 1'b1;
      @(negedge clk);
      n = is_nan(a) || is_nan(b);
      d = is_den(a) || is_den(b);
      t = (n && !mi) || (d && !md);
      ef = fi;
      tg = "R1";
      if (!t) begin
        ef = ef & ~M_ALL;
        va = value(a); vb = value(b);
        if (n) begin
          ef = ef | 16'h0045; tg = "R2";
        end else if (va == vb) begin
          ef = ef | 16'h0040;
          if (va == 0) tg = "R5";
        end else if (va < vb) begin
          ef = ef | 16'h0001;
        end
      end else begin
        tg = "R8";
      end
      chk("R9 out_valid", 32'(out_valid), 1);
      chk({tg, " flags"}, 32'(flags_out), 32'(ef));
      chk("R6 stat_inv", 32'(stat_inv), 32'(n));
      chk("R7 stat_den", 32'(stat_den), 32'(d));
      chk("R8 trap_req", 32'(trap_req), 32'(t));
      if (!t) begin
        chk("R3 oas cleared", 32'(flags_out & M_OAS), 0);
        chk("R4 passthrough", 32'(flags_out & ~M_ALL), 32'(fi & ~M_ALL));
      end
      if ((i % 509) == 17) begin
        last_out = flags_out;
        in_valid = 1'b0;
        flags_in = ~fi;
        @(negedge clk);
        chk("R9 idle valid", 32'(out_valid), 0);
        chk("R9 idle status", {29'd0, stat_inv, stat_den, trap_req}, 0);
        chk("R9 idle hold", 32'(flags_out), 32'(last_out));
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 late reset flags", 32'(flags_out), 0);
    chk("R10 late reset valid", 32'(out_valid), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule